// File: doc/BRIEF.md
# Counter CSR Access Unit with Privilege Gating

This block holds the shared cycle/retired-instruction counter of a hart. It answers reads and writes made at the counter's control-and-status addresses, from both the machine-level and the user-level address windows. Two enable registers are kept here: a machine-owned one and a supervisor-owned one. Together they decide whether code running below machine level may read a given user-level counter.

Performance counters 3 to 31 are not implemented, so their addresses read as zero when the access is legal. Machine-level event selector addresses also read as zero. When the hart runs with 32-bit registers, the 64-bit counter is read and written in two halves. Any read that is denied, or that lands on an address this block does not know, raises a combinational illegal-instruction flag for the decode stage.

Top module: `cnt_csr_access`

## Requirements
- R1: After reset the shared counter and both enable registers are zero.
- R2: The counter adds one on each clock edge where `retire_i` is high. A counter write in the same cycle wins over the increment.
- R3: Machine counter reads at 0xB00 and 0xB02 are always legal. They return the full counter in 64-bit mode and the zero-extended bits 31:0 in 32-bit mode (`xlen32_i`=1).
- R4: Writes to 0xB00 or 0xB02 replace the whole counter in 64-bit mode. In 32-bit mode they replace only bits 31:0. A write to 0xB80 or 0xB82 in 32-bit mode replaces bits 63:32 and keeps bits 31:0.
- R5: Reads of 0xB80 and 0xB82 return counter bits 63:32 in 32-bit mode and are illegal in 64-bit mode.
- R6: The permission for an address is one bit of a mask, selected by address bits 4:0. Privilege is encoded U=0, S=1, M=3. At M every bit of the mask is one. At S the mask is the machine enable register. At U the mask is the machine enable AND the supervisor enable.
- R7: User reads of 0xC00 and 0xC02 return the counter (same widths as R3) when permitted and are illegal otherwise.
- R8: User reads of 0xC03 to 0xC1F return 0 when permitted and are illegal otherwise. Reads of 0xC83 to 0xC9F behave the same way in 32-bit mode and are always illegal in 64-bit mode.
- R9: Reads of 0xB03 to 0xB1F and of 0x323 to 0x33F return 0 at any privilege. Reads of 0xB83 to 0xB9F return 0 in 32-bit mode and are illegal in 64-bit mode.
- R10: The machine enable register (0x306) and the supervisor enable register (0x106) take all 32 written bits and read them back.
- R11: Reading any other address, including 0xC01 and 0xB01, raises `illegal_o`. `illegal_o` stays low whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| xlen32_i | input | 1 | High when the hart runs with 32-bit registers |
| retire_i | input | 1 | Counter increment request for this cycle |
| csr_addr_i | input | 12 | CSR address of the access |
| rd_en_i | input | 1 | Read access this cycle |
| wr_en_i | input | 1 | Write access this cycle |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data (combinational) |
| illegal_o | output | 1 | Denied or unknown read (combinational) |

## Verification
A vector table reads one counter value under many mixes of privilege level, register width and address. The enable masks are chosen so that some bits are set in both masks, some only in the machine mask, and some in neither. This separates the user path from the supervisor path and shows the effect of the address-indexed bit. Directed sequences then cover counting under retire pulses, a write that collides with an increment, and split half writes that must leave the other half untouched. They also cover a full-width write, the reset values, and an unknown address presented with no read enable.

// File: rtl/cnt_csr_pkg.sv
package cnt_csr_pkg;

   localparam int ADDR_W = 12;

   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPV  = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;

   typedef enum logic [3:0] {
      K_NONE,
      K_UCNT,
      K_UHPM,
      K_UHPMH,
      K_MCNT,
      K_MCNTH,
      K_MZERO,
      K_MZEROH,
      K_MEN,
      K_SEN
   } kind_e;

   localparam logic [ADDR_W-1:0] A_MEN = 12'h306;
   localparam logic [ADDR_W-1:0] A_SEN = 12'h106;

   localparam logic [6:0] WIN_USER_LO = 7'b1100_000;
   localparam logic [6:0] WIN_USER_HI = 7'b1100_100;
   localparam logic [6:0] WIN_MACH_LO = 7'b1011_000;
   localparam logic [6:0] WIN_MACH_HI = 7'b1011_100;
   localparam logic [6:0] WIN_EVENT   = 7'b0011_001;

endpackage

// File: rtl/cnt_csr_decode.sv
module cnt_csr_decode
   import cnt_csr_pkg::*;
(
   input  logic [ADDR_W-1:0] addr_i,
   output kind_e             kind_o
);
   logic [6:0] win;
   logic [4:0] idx;
   logic       is_base;
   logic       is_upper;

   assign win      = addr_i[ADDR_W-1:5];
   assign idx      = addr_i[4:0];
   assign is_base  = (idx == 5'd0) || (idx == 5'd2);
   assign is_upper = (idx >= 5'd3);

   always_comb begin
      kind_o = K_NONE;
      if (addr_i == A_MEN)                        kind_o = K_MEN;
      else if (addr_i == A_SEN)                   kind_o = K_SEN;
      else if (win == WIN_USER_LO && is_base)     kind_o = K_UCNT;
      else if (win == WIN_USER_LO && is_upper)    kind_o = K_UHPM;
      else if (win == WIN_USER_HI && is_upper)    kind_o = K_UHPMH;
      else if (win == WIN_MACH_LO && is_base)     kind_o = K_MCNT;
      else if (win == WIN_MACH_LO && is_upper)    kind_o = K_MZERO;
      else if (win == WIN_MACH_HI && is_base)     kind_o = K_MCNTH;
      else if (win == WIN_MACH_HI && is_upper)    kind_o = K_MZEROH;
      else if (win == WIN_EVENT && is_upper)      kind_o = K_MZERO;
   end
endmodule

// File: rtl/cnt_csr_perm.sv
module cnt_csr_perm
   import cnt_csr_pkg::*;
#(
   parameter int EN_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      priv_i,
   input  logic            wr_men_i,
   input  logic            wr_sen_i,
   input  logic [EN_W-1:0] wr_data_i,
   input  logic [4:0]      idx_i,
   output logic [EN_W-1:0] men_o,
   output logic [EN_W-1:0] sen_o,
   output logic            perm_o
);
   localparam int IDX_W = $clog2(EN_W);

   if (EN_W != 32) begin : g_bad_w
      $error("cnt_csr_perm: EN_W must be 32 to match a 5-bit index");
   end

   logic [EN_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         men_o <= '0;
         sen_o <= '0;
      end else begin
         if (wr_men_i) men_o <= wr_data_i;
         if (wr_sen_i) sen_o <= wr_data_i;
      end
   end

   for (genvar b = 0; b < EN_W; b++) begin : g_mask
      assign mask[b] = (priv_i == LVL_MACH) ? 1'b1
                     : (priv_i == LVL_USER) ? (men_o[b] & sen_o[b])
                     : men_o[b];
   end

   assign perm_o = mask[idx_i[IDX_W-1:0]];

   a_r10_men_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_men_i |=> $stable(men_o));
   a_r10_sen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sen_i |=> $stable(sen_o));
endmodule

// File: rtl/cnt_csr_counter.sv
module cnt_csr_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             xlen32_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int HALF_W = CNT_W / 2;

   if (CNT_W % 2 != 0) begin : g_bad_w
      $error("cnt_csr_counter: CNT_W must be even");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (wr_lo_i) begin
         if (xlen32_i) cnt_o <= {cnt_o[CNT_W-1:HALF_W], wr_data_i[HALF_W-1:0]};
         else          cnt_o <= wr_data_i;
      end else if (wr_hi_i) begin
         cnt_o <= {wr_data_i[HALF_W-1:0], cnt_o[HALF_W-1:0]};
      end else if (retire_i) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + 1'b1);
   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!retire_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
   a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && xlen32_i) |=> cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W]));
   a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i && !wr_lo_i) |=> cnt_o[HALF_W-1:0] == $past(cnt_o[HALF_W-1:0]));
endmodule

// File: rtl/cnt_csr_access.sv
module cnt_csr_access
   import cnt_csr_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int CNT_W = 64,
   parameter int EN_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          priv_i,
   input  logic                xlen32_i,
   input  logic                retire_i,
   input  logic [ADDR_W-1:0]   csr_addr_i,
   input  logic                rd_en_i,
   input  logic                wr_en_i,
   input  logic [XLEN-1:0]     wr_data_i,
   output logic [XLEN-1:0]     rd_data_o,
   output logic                illegal_o
);
   localparam int HALF_W = CNT_W / 2;

   if (XLEN != CNT_W) begin : g_bad_xlen
      $error("cnt_csr_access: XLEN must equal CNT_W");
   end
   if (EN_W > XLEN) begin : g_bad_en
      $error("cnt_csr_access: EN_W must not exceed XLEN");
   end

   kind_e            kind;
   logic [CNT_W-1:0] cnt;
   logic [EN_W-1:0]  men, sen;
   logic             perm;
   logic             wr_lo, wr_hi;
   logic             bad;
   logic [XLEN-1:0]  cnt_low_view;

   cnt_csr_decode u_dec (
      .addr_i (csr_addr_i),
      .kind_o (kind)
   );

   assign wr_lo = wr_en_i && (kind == K_MCNT);
   assign wr_hi = wr_en_i && (kind == K_MCNTH) && xlen32_i;

   cnt_csr_perm #(.EN_W(EN_W)) u_perm (
      .clk       (clk),
      .rst_n     (rst_n),
      .priv_i    (priv_i),
      .wr_men_i  (wr_en_i && (kind == K_MEN)),
      .wr_sen_i  (wr_en_i && (kind == K_SEN)),
      .wr_data_i (wr_data_i[EN_W-1:0]),
      .idx_i     (csr_addr_i[4:0]),
      .men_o     (men),
      .sen_o     (sen),
      .perm_o    (perm)
   );

   cnt_csr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire_i  (retire_i),
      .xlen32_i  (xlen32_i),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wr_data_i (wr_data_i),
      .cnt_o     (cnt)
   );

   assign cnt_low_view = xlen32_i ? {{(XLEN-HALF_W){1'b0}}, cnt[HALF_W-1:0]} : cnt;

   always_comb begin
      bad       = 1'b0;
      rd_data_o = '0;
      case (kind)
         K_UCNT:   begin bad = !perm; rd_data_o = cnt_low_view; end
         K_UHPM:   bad = !perm;
         K_UHPMH:  bad = !(perm && xlen32_i);
         K_MCNT:   rd_data_o = cnt_low_view;
         K_MCNTH:  begin
                      bad       = !xlen32_i;
                      rd_data_o = {{(XLEN-HALF_W){1'b0}}, cnt[CNT_W-1:HALF_W]};
                   end
         K_MZERO:  bad = 1'b0;
         K_MZEROH: bad = !xlen32_i;
         K_MEN:    rd_data_o = {{(XLEN-EN_W){1'b0}}, men};
         K_SEN:    rd_data_o = {{(XLEN-EN_W){1'b0}}, sen};
         default:  bad = 1'b1;
      endcase
   end

   assign illegal_o = rd_en_i && bad;

   a_r11_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> !illegal_o);
   a_r3_machine_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && kind == K_MCNT) |-> !illegal_o);
   a_r6_mach_user_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && kind == K_UCNT && priv_i == LVL_MACH) |-> !illegal_o);
   a_r6_user_needs_men: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && kind == K_UCNT && priv_i == LVL_USER && !men[csr_addr_i[4:0]])
         |-> illegal_o);
   a_r5_hi_illegal_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && kind == K_MCNTH && !xlen32_i) |-> illegal_o);
endmodule

// File: tb/cnt_csr_access_bench.sv
`timescale 1ns/1ps
module cnt_csr_access_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  priv_i = 2'd3;
   logic        xlen32_i = 1'b0;
   logic        retire_i = 1'b0;
   logic [11:0] csr_addr_i = 12'h000;
   logic        rd_en_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [63:0] wr_data_i = '0;
   logic [63:0] rd_data_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cnt_csr_access u_cnt_csr_access (
      .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .xlen32_i(xlen32_i),
      .retire_i(retire_i), .csr_addr_i(csr_addr_i), .rd_en_i(rd_en_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .illegal_o(illegal_o)
   );

   localparam logic [63:0] CV = 64'h1234_5678_9ABC_DEF0;
   localparam logic [31:0] MEN_V = 32'h0000_000D;
   localparam logic [31:0] SEN_V = 32'h0000_0001;
   // {priv, xlen32, addr, expect_illegal, expect_data}
   localparam int NV = 20;
   localparam logic [79:0] VEC [NV] = '{
      {2'd0, 1'b0, 12'hC00, 1'b0, CV},                    // R7 user, both bits set
      {2'd0, 1'b0, 12'hC02, 1'b1, 64'h0},                 // R7 user, sup bit clear
      {2'd1, 1'b0, 12'hC02, 1'b0, CV},                    // R6 sup uses machine mask
      {2'd1, 1'b0, 12'hC03, 1'b0, 64'h0},                 // R8 permitted hpm
      {2'd1, 1'b0, 12'hC04, 1'b1, 64'h0},                 // R8 denied hpm
      {2'd0, 1'b0, 12'hC03, 1'b1, 64'h0},                 // R6 user needs both
      {2'd3, 1'b0, 12'hC04, 1'b0, 64'h0},                 // R6 machine all ones
      {2'd3, 1'b0, 12'hB00, 1'b0, CV},                    // R3 full width
      {2'd0, 1'b1, 12'hB02, 1'b0, {32'h0, CV[31:0]}},     // R3 low half view
      {2'd3, 1'b0, 12'hB80, 1'b1, 64'h0},                 // R5 wide mode illegal
      {2'd3, 1'b1, 12'hB82, 1'b0, {32'h0, CV[63:32]}},    // R5 upper half
      {2'd0, 1'b0, 12'hB05, 1'b0, 64'h0},                 // R9 no gating
      {2'd0, 1'b0, 12'h330, 1'b0, 64'h0},                 // R9 event selector
      {2'd3, 1'b0, 12'hB90, 1'b1, 64'h0},                 // R9 high, wide mode
      {2'd1, 1'b1, 12'hB90, 1'b0, 64'h0},                 // R9 high, narrow
      {2'd3, 1'b0, 12'hC01, 1'b1, 64'h0},                 // R11 unlisted
      {2'd3, 1'b0, 12'h000, 1'b1, 64'h0},                 // R11 unlisted
      {2'd3, 1'b0, 12'hC83, 1'b1, 64'h0},                 // R8 high, wide mode
      {2'd1, 1'b1, 12'hC83, 1'b0, 64'h0},                 // R8 high, narrow, permitted
      {2'd1, 1'b1, 12'hC84, 1'b1, 64'h0}                  // R8 high, narrow, denied
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic x32);
      @(negedge clk);
      csr_addr_i = a; wr_data_i = d; xlen32_i = x32; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] p, input logic x32, input logic [11:0] a,
                     output logic [63:0] d, output logic ill);
      @(negedge clk);
      priv_i = p; xlen32_i = x32; csr_addr_i = a; rd_en_i = 1'b1;
      #1;
      d = rd_data_o; ill = illegal_o;
      rd_en_i = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic        ill;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R1 counter", d, 64'h0);
      rd(2'd3, 1'b0, 12'h306, d, ill); check("R1 men", d, 64'h0);
      rd(2'd3, 1'b0, 12'h106, d, ill); check("R1 sen", d, 64'h0);

      // R10 enable registers
      wr(12'h306, {32'hFFFF_0000, MEN_V}, 1'b0);
      wr(12'h106, {32'h0, SEN_V}, 1'b0);
      rd(2'd0, 1'b0, 12'h306, d, ill); check("R10 men readback", d, {32'h0, MEN_V});
      rd(2'd0, 1'b0, 12'h106, d, ill); check("R10 sen readback", d, {32'h0, SEN_V});

      // R4 full write in 64-bit mode
      wr(12'hB02, CV, 1'b0);
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R4 full write", d, CV);

      for (int i = 0; i < NV; i++) begin
         rd(VEC[i][79:78], VEC[i][77], VEC[i][76:65], d, ill);
         check($sformatf("vec %0d illegal", i), {63'h0, ill}, {63'h0, VEC[i][64]});
         if (!VEC[i][64]) check($sformatf("vec %0d data", i), d, VEC[i][63:0]);
      end

      // R2 increments
      @(negedge clk); retire_i = 1'b1;
      repeat (5) @(negedge clk);
      retire_i = 1'b0;
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R2 five retires", d, CV + 64'd5);

      // R2 write wins over increment
      @(negedge clk);
      csr_addr_i = 12'hB00; wr_data_i = 64'h0000_0000_FFFF_FFFF; xlen32_i = 1'b0;
      wr_en_i = 1'b1; retire_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; retire_i = 1'b0;
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R2 write priority", d, 64'h0000_0000_FFFF_FFFF);

      // R2 carry across halves
      @(negedge clk); retire_i = 1'b1;
      @(negedge clk); retire_i = 1'b0;
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R2 carry", d, 64'h0000_0001_0000_0000);

      // R4 split writes in 32-bit mode
      wr(12'hB00, 64'hDEAD_BEEF_CAFE_F00D, 1'b1);
      rd(2'd3, 1'b1, 12'hB80, d, ill); check("R4 low write keeps high", d, 64'h1);
      rd(2'd3, 1'b1, 12'hB00, d, ill); check("R4 low write value", d, 64'hCAFE_F00D);
      wr(12'hB82, 64'h1111_2222_ABCD_0123, 1'b1);
      rd(2'd3, 1'b0, 12'hB00, d, ill); check("R4 high write keeps low", d, 64'hABCD_0123_CAFE_F00D);

      // R11 no read enable: unknown address does not flag
      @(negedge clk);
      csr_addr_i = 12'h7FF; rd_en_i = 1'b0;
      #1;
      check("R11 no read, no flag", {63'h0, illegal_o}, 64'h0);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule